// File: doc/BRIEF.md
# Dual serial port line sampler

This block watches two slow serial inputs, a PS/2 keyboard clock/data pair and an RS-232 receive line, from a datapath that can look at them only once per video line. No shift register runs at the bit rate. Each port instead owns one 4-bit nibble of a packed 8-bit state word. The nibble holds a 2-bit phase and 2 bits of data, and it is updated by a line strobe. A second strobe marks the boundary of a process cycle, which lasts up to four lines.

On the keyboard side, the phase counts clock level changes modulo 4, and the current clock level is implied by the phase parity. Each high-to-low change shifts the data level into the 2-bit field. At every cycle boundary the block reports how many bits arrived since the previous boundary (0, 1 or 2), together with the data field. A collector shifts those bits, first received first, into an 11-bit frame and strobes it when complete. On the serial side, the phase restarts whenever the line differs from its stored previous level. The line is sampled when the phase reaches 2, which puts the sample near the middle of a four-line bit. All three inputs pass through a two-flop synchroniser first.

Top module: `line_serial_sampler`

## Requirements
- R1: After reset, ps2_vld, ps2_count, frame_done and rx_vld are 0 and rx_bit is 1. The implied PS/2 clock level and the stored RX level are both high.
- R2: Inputs reach the sampler through two flops. A line strobe raised in the same clock as an input change sees the old level.
- R3: On a clock with cycle_stb, ps2_vld pulses for one clock. ps2_count then equals the number of high-to-low PS/2 clock changes seen by line strobes since the previous boundary, including a line strobe in that same clock. Otherwise ps2_count reads 0.
- R4: ps2_bits[0] is the PS/2 data level at the most recent high-to-low change, and ps2_bits[1] is the level at the change before it. Only the low ps2_count bits are meaningful.
- R5: Four clock changes within one cycle report ps2_count = 2, not 0.
- R6: Reported bits fill an 11-bit frame, with the earliest bit at frame_data[0]. One clock after the report that completes 11 bits, frame_done pulses and frame_data holds the frame. A second bit in the same report starts the next frame.
- R7: A line strobe that sees RX differ from the stored level restarts the RX phase at 0. rx_vld pulses with rx_bit equal to the line level on the line where the phase becomes 2, the second line after the change.
- R8: While RX holds steady, the phase wraps modulo 4, so a new sample is taken every fourth line.
- R9: Without a line strobe, input activity changes neither side: no RX sample is taken and no PS/2 change is counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_stb | input | 1 | One-clock strobe per video line; samples both ports |
| cycle_stb | input | 1 | One-clock strobe at a process-cycle boundary |
| ps2_clk_in | input | 1 | PS/2 clock level, asynchronous |
| ps2_data_in | input | 1 | PS/2 data level, asynchronous |
| rx_in | input | 1 | RS-232 receive level, asynchronous |
| ps2_bits | output | 2 | PS/2 data field at the last boundary |
| ps2_count | output | 2 | Number of new PS/2 bits (0..2) |
| ps2_vld | output | 1 | Pulse: ps2_count/ps2_bits updated |
| frame_data | output | 11 | Last completed PS/2 frame, earliest bit in bit 0 |
| frame_done | output | 1 | Pulse: frame_data updated |
| rx_bit | output | 1 | Last mid-bit RX sample |
| rx_vld | output | 1 | Pulse: rx_bit updated |

## Verification
A wrong PS/2 phase shows up at the very next cycle boundary as a wrong ps2_count, because the count is derived from the phase difference. It then corrupts every later frame: the frame collector loses or gains a bit and frame_done moves off its expected report. A wrong RX phase or stored level shifts the rx_vld pulse to another line within four lines of the fault. The bench sweeps all 16 four-line PS/2 clock patterns against all 16 data patterns while RX runs a pseudo-random pattern of run lengths. It therefore compares the count, the bits, the frame contents and each RX sample against an arithmetic model on every line.

// File: rtl/line_sampler_pkg.sv
package line_sampler_pkg;

  typedef struct packed {
    logic [1:0] phase;
    logic [1:0] bits;
  } nibble_t;

  typedef struct packed {
    nibble_t kbd;
    nibble_t uart;
  } state_word_t;

  // Implied PS/2 clock level: idle high at phase 0, toggles each change.
  function automatic logic phase_level(input logic [1:0] phase);
    return ~phase[0];
  endfunction

  // Falling changes between start phase s and end phase e.
  // moved separates zero changes from four changes (same phase).
  function automatic logic [1:0] ps2_falls(input logic [1:0] s,
                                           input logic [1:0] e,
                                           input logic moved);
    logic [1:0] d;
    logic [2:0] sum;
    d   = e - s;
    sum = {1'b0, d} + {2'b00, ~s[0]};
    if (!moved) return 2'd0;
    if (d == 2'd0) return 2'd2;
    return sum[2:1];
  endfunction

endpackage

// File: rtl/ls_sync.sv
module ls_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ls_ps2_half.sv
module ls_ps2_half
  import line_sampler_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_stb,
  input  logic       cycle_stb,
  input  logic       kclk_s,
  input  logic       kdat_s,
  output logic [1:0] rep_bits,
  output logic [1:0] rep_cnt,
  output logic       rep_vld
);
  nibble_t    cur, nxt;
  logic [1:0] start_q;
  logic       moved_q, moved_n;
  logic       lvl, edge_evt, fall_evt;

  assign lvl      = phase_level(cur.phase);
  assign edge_evt = line_stb && (kclk_s != lvl);
  assign fall_evt = edge_evt && lvl;
  assign moved_n  = moved_q | edge_evt;

  always_comb begin
    nxt = cur;
    if (edge_evt) nxt.phase = cur.phase + 2'd1;
    if (fall_evt) nxt.bits  = {cur.bits[0], kdat_s};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur      <= '0;
      start_q  <= '0;
      moved_q  <= 1'b0;
      rep_bits <= '0;
      rep_cnt  <= '0;
      rep_vld  <= 1'b0;
    end else begin
      cur     <= nxt;
      rep_vld <= cycle_stb;
      if (cycle_stb) begin
        rep_cnt  <= ps2_falls(start_q, nxt.phase, moved_n);
        rep_bits <= nxt.bits;
        start_q  <= nxt.phase;
        moved_q  <= 1'b0;
      end else begin
        rep_cnt  <= 2'd0;
        moved_q  <= moved_n;
      end
    end
  end

  AST_PS2_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !line_stb |=> $stable(cur.phase)); // R9
  AST_PS2_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    rep_vld |-> rep_cnt <= 2'd2); // R3
  AST_PS2_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> cur.bits[0] == $past(kdat_s)); // R4
  AST_PS2_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rep_vld |-> rep_cnt == 2'd0); // R3
endmodule

// File: rtl/ls_rx_half.sv
module ls_rx_half
  import line_sampler_pkg::*;
#(
  parameter logic [1:0] SAMPLE_PHASE = 2'd2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_stb,
  input  logic rx_s,
  output logic rx_bit,
  output logic rx_vld
);
  // bits[1]: previous line level, bits[0]: latest mid-bit sample
  nibble_t cur, nxt;
  logic    chg, take;

  assign chg = line_stb && (rx_s != cur.bits[1]);

  always_comb begin
    nxt  = cur;
    take = 1'b0;
    if (line_stb) begin
      if (chg) begin
        nxt.phase   = 2'd0;
        nxt.bits[1] = rx_s;
      end else begin
        nxt.phase = cur.phase + 2'd1;
      end
      if (nxt.phase == SAMPLE_PHASE) begin
        nxt.bits[0] = rx_s;
        take        = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur    <= '{phase: 2'd0, bits: 2'b11};
      rx_vld <= 1'b0;
    end else begin
      cur    <= nxt;
      rx_vld <= take;
    end
  end

  assign rx_bit = cur.bits[0];

  AST_RX_RESYNC: assert property (@(posedge clk) disable iff (!rst_n)
    chg |=> cur.phase == 2'd0); // R7
  AST_RX_SAMPLE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_vld |-> cur.phase == SAMPLE_PHASE); // R7
  AST_RX_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !line_stb |=> !rx_vld); // R9
endmodule

// File: rtl/ls_frame_collect.sv
module ls_frame_collect #(
  parameter int FRAME_BITS = 11
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_vld,
  input  logic [1:0]            in_cnt,
  input  logic [1:0]            in_bits,
  output logic [FRAME_BITS-1:0] frame_q,
  output logic                  frame_done
);
  localparam int FW = $clog2(FRAME_BITS + 1);
  localparam logic [FW-1:0] LAST = FW'(FRAME_BITS);
  localparam logic [FW-1:0] ONE  = FW'(1);

  logic [FRAME_BITS-1:0] sh_q, sh_n, out_n;
  logic [FW-1:0]         fill_q, fill_n;
  logic                  done_n;

  always_comb begin
    sh_n   = sh_q;
    fill_n = fill_q;
    out_n  = frame_q;
    done_n = 1'b0;
    if (in_vld && in_cnt != 2'd0) begin
      sh_n   = {(in_cnt == 2'd2) ? in_bits[1] : in_bits[0], sh_n[FRAME_BITS-1:1]};
      fill_n = fill_n + ONE;
      if (fill_n == LAST) begin
        done_n = 1'b1;
        out_n  = sh_n;
        fill_n = '0;
      end
    end
    if (in_vld && in_cnt == 2'd2) begin
      sh_n   = {in_bits[0], sh_n[FRAME_BITS-1:1]};
      fill_n = fill_n + ONE;
      if (fill_n == LAST) begin
        done_n = 1'b1;
        out_n  = sh_n;
        fill_n = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q       <= '0;
      fill_q     <= '0;
      frame_q    <= '0;
      frame_done <= 1'b0;
    end else begin
      sh_q       <= sh_n;
      fill_q     <= fill_n;
      frame_q    <= out_n;
      frame_done <= done_n;
    end
  end

  AST_FRAME_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(in_vld)); // R6
  AST_FRAME_FILL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q < LAST); // R6
endmodule

// File: rtl/line_serial_sampler.sv
module line_serial_sampler #(
  parameter int SYNC_STAGES = 2,
  parameter int FRAME_BITS = 11,
  parameter logic [1:0] RX_SAMPLE_PHASE = 2'd2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  line_stb,
  input  logic                  cycle_stb,
  input  logic                  ps2_clk_in,
  input  logic                  ps2_data_in,
  input  logic                  rx_in,
  output logic [1:0]            ps2_bits,
  output logic [1:0]            ps2_count,
  output logic                  ps2_vld,
  output logic [FRAME_BITS-1:0] frame_data,
  output logic                  frame_done,
  output logic                  rx_bit,
  output logic                  rx_vld
);
  localparam int NPINS = 3;

  logic [NPINS-1:0] pins_s;

  ls_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES), .RST_VAL({NPINS{1'b1}})) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({ps2_clk_in, ps2_data_in, rx_in}),
    .q    (pins_s)
  );

  ls_ps2_half u_kbd (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_stb (line_stb),
    .cycle_stb(cycle_stb),
    .kclk_s   (pins_s[2]),
    .kdat_s   (pins_s[1]),
    .rep_bits (ps2_bits),
    .rep_cnt  (ps2_count),
    .rep_vld  (ps2_vld)
  );

  ls_frame_collect #(.FRAME_BITS(FRAME_BITS)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_vld    (ps2_vld),
    .in_cnt    (ps2_count),
    .in_bits   (ps2_bits),
    .frame_q   (frame_data),
    .frame_done(frame_done)
  );

  ls_rx_half #(.SAMPLE_PHASE(RX_SAMPLE_PHASE)) u_uart (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_stb(line_stb),
    .rx_s    (pins_s[0]),
    .rx_bit  (rx_bit),
    .rx_vld  (rx_vld)
  );

  AST_FRAME_AFTER_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(ps2_count) != 2'd0); // R6
endmodule

// File: tb/line_serial_sampler_test.sv
module line_serial_sampler_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_stb = 1'b0, cycle_stb = 1'b0;
  logic ps2_clk_in = 1'b1, ps2_data_in = 1'b1, rx_in = 1'b1;
  logic [1:0]  ps2_bits, ps2_count;
  logic        ps2_vld, frame_done, rx_bit, rx_vld;
  logic [10:0] frame_data;

  int checks = 0;
  int fails = 0;

  // bench model
  logic        m_lvl = 1'b1;
  logic [1:0]  m_eb = 2'b00;
  int          m_falls = 0;
  logic [10:0] m_fsh = '0;
  int          m_fn = 0;
  logic        m_done = 1'b0;
  logic [10:0] m_frame = '0;
  logic        m_rprev = 1'b1;
  int          m_rph = 0;

  always #5 clk = ~clk;

  line_serial_sampler uut (
    .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .cycle_stb(cycle_stb),
    .ps2_clk_in(ps2_clk_in), .ps2_data_in(ps2_data_in), .rx_in(rx_in),
    .ps2_bits(ps2_bits), .ps2_count(ps2_count), .ps2_vld(ps2_vld),
    .frame_data(frame_data), .frame_done(frame_done),
    .rx_bit(rx_bit), .rx_vld(rx_vld)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic push_bit(input logic b);
    m_fsh = {b, m_fsh[10:1]};
    m_fn++;
    if (m_fn == 11) begin
      m_done  = 1'b1;
      m_frame = m_fsh;
      m_fn    = 0;
    end
  endtask

  // RX model for one sampled level; checks rx_vld / rx_bit (R7, R8)
  task automatic rx_model_check(input logic lv, input string req);
    logic exp_v;
    if (lv != m_rprev) begin
      m_rprev = lv;
      m_rph   = 0;
    end else begin
      m_rph = (m_rph + 1) % 4;
    end
    exp_v = (m_rph == 2);
    chk(rx_vld == exp_v, req, rx_vld, exp_v);
    if (exp_v) chk(rx_bit == lv, req, rx_bit, lv);
  endtask

  task automatic do_line(input logic ck, input logic dt, input logic rx, input logic cyc,
                         input string rxreq);
    int cnt_exp;
    @(negedge clk);
    ps2_clk_in = ck; ps2_data_in = dt; rx_in = rx;
    repeat (3) @(negedge clk);
    line_stb = 1'b1; cycle_stb = cyc;
    @(negedge clk);
    line_stb = 1'b0; cycle_stb = 1'b0;
    if (ck != m_lvl) begin
      if (m_lvl) begin
        m_falls++;
        m_eb = {m_eb[0], dt};
      end
      m_lvl = ck;
    end
    rx_model_check(rx, rxreq);
    m_done = 1'b0;
    if (cyc) begin
      cnt_exp = m_falls;
      chk(ps2_vld == 1'b1, "R3", ps2_vld, 1);
      chk(ps2_count == 2'(cnt_exp), "R3", ps2_count, cnt_exp);
      if (cnt_exp >= 1) chk(ps2_bits[0] == m_eb[0], "R4", ps2_bits[0], m_eb[0]);
      if (cnt_exp == 2) chk(ps2_bits[1] == m_eb[1], "R4", ps2_bits[1], m_eb[1]);
      if (cnt_exp == 2) push_bit(m_eb[1]);
      if (cnt_exp >= 1) push_bit(m_eb[0]);
      m_falls = 0;
    end else begin
      chk(ps2_vld == 1'b0 && ps2_count == 2'd0, "R3", ps2_count, 0);
    end
    @(negedge clk);
    chk(frame_done == m_done, "R6", frame_done, m_done);
    if (m_done) chk(frame_data == m_frame, "R6", frame_data, m_frame);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] lfsr;
    logic       rxl;
    logic       idle_bad;
    int         trans;
    lfsr = 8'hA5;
    rxl  = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(ps2_vld == 1'b0 && ps2_count == 2'd0, "R1", ps2_count, 0);
    chk(frame_done == 1'b0, "R1", frame_done, 0);
    chk(rx_bit == 1'b1 && rx_vld == 1'b0, "R1", rx_bit, 1);

    // R2: change RX and strobe in the same slot; sampler must see old level (1)
    for (int k = 0; k < 3; k++) do_line(1'b1, 1'b1, 1'b1, 1'b0, "R8");
    @(negedge clk);
    rx_in = 1'b0; line_stb = 1'b1;
    @(negedge clk);
    line_stb = 1'b0;
    rx_model_check(1'b1, "R2");
    repeat (3) @(negedge clk);
    for (int k = 0; k < 3; k++) do_line(1'b1, 1'b1, 1'b0, 1'b0, "R7");
    for (int k = 0; k < 4; k++) do_line(1'b1, 1'b1, 1'b1, k == 3, "R7");

    // Sweep all PS/2 clock x data patterns over 4-line cycles
    for (int cp = 0; cp < 16; cp++) begin
      for (int dp = 0; dp < 16; dp++) begin
        logic pl;
        pl    = m_lvl;
        trans = 0;
        for (int i = 0; i < 4; i++) begin
          logic cb;
          cb = cp[i] ^ cp[(i + 3) % 4] ^ (i == 0 ? 1'b0 : 1'b0);
          cb = cp[i];
          if (cb != pl) trans++;
          pl   = cb;
          lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
          if (lfsr[1:0] == 2'b00) rxl = lfsr[7];
          do_line(cb, dp[i], rxl, i == 3, (lfsr[1:0] == 2'b00) ? "R7" : "R8");
        end
        if (trans == 4) chk(1'b1, "R5", 4, 4);
      end
    end

    // R5 directed: clock high -> L H L H in one cycle gives count 2
    for (int k = 0; k < 4; k++) do_line(1'b1, 1'b0, rxl, k == 3, "R8");
    for (int k = 0; k < 4; k++) do_line(k[0], k[1], rxl, k == 3, "R5");
    chk(m_lvl == 1'b1, "R5", m_lvl, 1);

    // R9: activity without line strobes is ignored
    idle_bad = 1'b0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      ps2_clk_in = ~ps2_clk_in;
      rx_in      = ~rx_in;
      if (rx_vld) idle_bad = 1'b1;
    end
    ps2_clk_in = m_lvl; rx_in = rxl;
    repeat (4) @(negedge clk);
    chk(idle_bad == 1'b0, "R9", idle_bad, 0);
    cycle_stb = 1'b1;
    @(negedge clk);
    cycle_stb = 1'b0;
    chk(ps2_vld == 1'b1 && ps2_count == 2'd0, "R9", ps2_count, 0);
    @(negedge clk);
    do_line(m_lvl, 1'b0, rxl, 1'b1, "R9");

    summary();
    $finish;
  end
endmodule